// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits on the controller side of an asynchronous DRAM that has one shared row/column address bus and four active-low strobes: row select, column select, write enable and output enable. A client hands it read or write requests, each carrying a row, a column and write data. The sequencer places the row on the address pins and drops the row strobe. After a programmable delay it places the column on the same pins and pulses the column strobe. On a read, the data the device returns is captured and sent back with a one-cycle response pulse.

The row stays open after an access. Later requests to the same row skip the row phase, so only the column strobe toggles. A request to a different row closes the open row first and waits out the precharge time before a new row strobe. An internal timer raises a refresh request at a fixed interval. The refresh is served ahead of any new request once the current access ends. It consists of a row-strobe-only dummy access to the next row in a wrapping counter, and it leaves no row open. All delays are counted in controller clock cycles.

Top module: `dram_page_seq`

## Requirements
- R1: While reset is held and in the cycle after it, all four strobe pins are high, the data driver is off, no response is flagged and a new request is accepted (ready high).
- R2: From the idle state, an accepted request drops the row strobe in the next cycle with the row on the address pins. The column strobe falls T_RCD+1 cycles after the row strobe, with the column on the pins. The response pulse comes T_RCD+T_CAS+2 cycles after the accept cycle.
- R3: Each column-strobe pulse lasts exactly T_CAS cycles.
- R4: A request to the open row is accepted in the cycle it is presented, with no row-strobe activity, and it responds T_CAS+2 cycles after acceptance.
- R5: The row strobe never falls again until it has been high for at least T_RP cycles. A request to a different row is accepted only after a wait of T_RP+1 cycles, and it then follows the timing of R2.
- R6: On a write, write enable is already low in the cycle before the column strobe falls and stays unchanged while the column strobe is low. Output enable stays high, and the data driver is on with the request data, which is stored at the addressed location.
- R7: On a read, output enable is already low in the cycle before the column strobe falls (early read). The response carries the byte found at the addressed row and column.
- R8: Every REF_INTERVAL cycles a refresh runs: the row strobe goes low without any column pulse. The refresh rows are 0, 1, 2 and onward in turn. Afterwards no row is open, so the next request takes the full R2 timing.
- R9: A pending refresh beats a waiting request to the open row. That request stalls until the refresh has finished and is then served with the full R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | controller clock |
| rstN | input | 1 | active-low synchronous reset |
| reqValid | input | 1 | request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | ADDR_W | row of the request |
| reqCol | input | ADDR_W | column of the request |
| reqWdata | input | DATA_W | write data |
| reqReady | output | 1 | request taken at this edge when reqValid is high |
| rspValid | output | 1 | one-cycle completion pulse |
| rspRdata | output | DATA_W | read data, valid with rspValid on reads |
| dramAddr | output | ADDR_W | multiplexed row/column address |
| dramRasN | output | 1 | row strobe, active low |
| dramCasN | output | 1 | column strobe, active low |
| dramWeN | output | 1 | write enable, active low |
| dramOeN | output | 1 | output enable, active low |
| dramDqOut | output | DATA_W | data toward the device |
| dramDqOe | output | 1 | drive enable for dramDqOut |
| dramDqIn | input | DATA_W | data from the device |

## Verification
Each request has two measured delays: the wait from first presentation to acceptance, and the delay from the accept cycle to the response pulse. The bench predicts both from the request's kind: 0 and T_RP+1 cycles for the wait, T_CAS+2 and T_RCD+T_CAS+2 cycles for the response. It counts cycles on falling clock edges, after the registered outputs have settled. A pin monitor in the device model tracks the strobe timing one falling edge at a time, and any strobe, width or gap rule it finds broken is charged to its requirement. Refresh effects are judged only after a refresh has been seen on the pins, which keeps them clear of the timer's phase.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVATE,
    ST_COL,
    ST_OPEN,
    ST_PRECHARGE,
    ST_REFRESH
  } seq_state_e;

  // strobes from control to datapath, active high
  typedef struct packed {
    logic rasOn;
    logic casOn;
    logic weOn;
    logic oeOn;
    logic dqDrive;
    logic selCol;
    logic selRef;
    logic take;
    logic done;
    logic refStep;
  } seq_strobe_t;

endpackage

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
#(
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 3,
  parameter int T_REF_ACT    = 2,
  parameter int REF_INTERVAL = 1024,
  parameter bit LATE_OE      = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rowHit,
  input  logic        pendWrite,
  output logic        reqReady,
  output seq_strobe_t strobe
);

  localparam int MAX_A = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int MAX_B = (T_RP > T_REF_ACT) ? T_RP : T_REF_ACT;
  localparam int MAXT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam int TMR_W = $clog2(REF_INTERVAL);

  localparam logic [CNT_W-1:0] RCD_M1 = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] CAS_N  = CNT_W'(T_CAS);
  localparam logic [CNT_W-1:0] RP_M1  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RP_N   = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] REF_M1 = CNT_W'(T_REF_ACT - 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REF_INTERVAL - 1);

  seq_state_e       state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic [TMR_W-1:0] refTimer;
  logic             refPending;
  logic             refFire;
  logic             refTake;
  logic             oeWindow;

  // output-enable placement inside the column phase
  generate
    if (LATE_OE) begin : g_lateOe
      assign oeWindow = (cnt < CNT_W'(T_CAS - 1));
    end else begin : g_earlyOe
      assign oeWindow = 1'b1;
    end
  endgenerate

  assign refFire  = (refTimer == TMR_LAST);
  assign reqReady = !refPending &&
                    ((state == ST_IDLE) || ((state == ST_OPEN) && rowHit));

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextCnt   = (cnt == '0) ? cnt : cnt - 1'b1;
    refTake   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (refPending) begin
          nextState = ST_REFRESH;
          nextCnt   = REF_M1;
          refTake   = 1'b1;
        end else if (reqValid) begin
          strobe.take = 1'b1;
          nextState   = ST_ACTIVATE;
          nextCnt     = RCD_M1;
        end
      end
      ST_ACTIVATE: begin
        strobe.rasOn = 1'b1;
        if (cnt == '0) begin
          nextState = ST_COL;
          nextCnt   = CAS_N;
        end
      end
      ST_COL: begin
        strobe.rasOn   = 1'b1;
        strobe.selCol  = 1'b1;
        strobe.casOn   = (cnt != CAS_N);
        strobe.weOn    = pendWrite;
        strobe.dqDrive = pendWrite;
        strobe.oeOn    = !pendWrite && oeWindow;
        if (cnt == '0) begin
          strobe.done = 1'b1;
          nextState   = ST_OPEN;
        end
      end
      ST_OPEN: begin
        strobe.rasOn = 1'b1;
        if (refPending) begin
          nextState = ST_PRECHARGE;
          nextCnt   = RP_M1;
        end else if (reqValid && rowHit) begin
          strobe.take = 1'b1;
          nextState   = ST_COL;
          nextCnt     = CAS_N;
        end else if (reqValid) begin
          nextState = ST_PRECHARGE;
          nextCnt   = RP_M1;
        end
      end
      ST_PRECHARGE: begin
        if (cnt == '0) nextState = ST_IDLE;
      end
      ST_REFRESH: begin
        strobe.rasOn  = 1'b1;
        strobe.selRef = 1'b1;
        if (cnt == '0) begin
          strobe.refStep = 1'b1;
          nextState      = ST_PRECHARGE;
          nextCnt        = RP_M1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      refTimer   <= '0;
      refPending <= 1'b0;
    end else begin
      state      <= nextState;
      cnt        <= nextCnt;
      refTimer   <= refFire ? '0 : refTimer + 1'b1;
      refPending <= refFire ? 1'b1 : (refTake ? 1'b0 : refPending);
    end
  end

  // run-length counters for the strobe checks
  logic [CNT_W-1:0] rasHighRun;
  logic [CNT_W-1:0] casLowRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasHighRun <= RP_N;
      casLowRun  <= '0;
    end else begin
      rasHighRun <= strobe.rasOn ? '0 :
                    ((rasHighRun >= RP_N) ? RP_N : rasHighRun + 1'b1);
      casLowRun  <= strobe.casOn ?
                    ((casLowRun == '1) ? casLowRun : casLowRun + 1'b1) : '0;
    end
  end

  // R5
  ras_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.rasOn) |-> rasHighRun >= RP_N);

  // R3
  cas_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.casOn) |-> casLowRun == CAS_N);

endmodule

// File: rtl/dps_dpath.sv
module dps_dpath
  import dps_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [ADDR_W-1:0] reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  input  seq_strobe_t       strobe,
  output logic              rowHit,
  output logic              pendWrite,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic              dramOeN,
  output logic [DATA_W-1:0] dramDqOut,
  output logic              dramDqOe,
  input  logic [DATA_W-1:0] dramDqIn
);

  logic [ADDR_W-1:0] rowQ, colQ, refRow;
  logic [DATA_W-1:0] dataQ;
  logic              writeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ     <= '0;
      colQ     <= '0;
      dataQ    <= '0;
      writeQ   <= 1'b0;
      refRow   <= '0;
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      if (strobe.take) begin
        rowQ   <= reqRow;
        colQ   <= reqCol;
        dataQ  <= reqWdata;
        writeQ <= reqWrite;
      end
      if (strobe.refStep) refRow <= refRow + 1'b1;
      rspValid <= strobe.done;
      if (strobe.done && !writeQ) rspRdata <= dramDqIn;
    end
  end

  assign rowHit    = (reqRow == rowQ);
  assign pendWrite = writeQ;

  assign dramAddr  = strobe.selRef ? refRow : (strobe.selCol ? colQ : rowQ);
  assign dramRasN  = ~strobe.rasOn;
  assign dramCasN  = ~strobe.casOn;
  assign dramWeN   = ~strobe.weOn;
  assign dramOeN   = ~strobe.oeOn;
  assign dramDqOut = dataQ;
  assign dramDqOe  = strobe.dqDrive;

  // R6
  we_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> $stable(dramWeN));

  // R7
  rsp_after_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(!dramCasN));

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 3,
  parameter int T_REF_ACT    = 2,
  parameter int REF_INTERVAL = 1024,
  parameter bit LATE_OE      = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [ADDR_W-1:0] reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic              dramOeN,
  output logic [DATA_W-1:0] dramDqOut,
  output logic              dramDqOe,
  input  logic [DATA_W-1:0] dramDqIn
);

  dps_pkg::seq_strobe_t strobe;
  logic rowHit;
  logic pendWrite;

  dps_ctrl #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_REF_ACT(T_REF_ACT),
    .REF_INTERVAL(REF_INTERVAL), .LATE_OE(LATE_OE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rowHit(rowHit),
    .pendWrite(pendWrite), .reqReady(reqReady), .strobe(strobe)
  );

  dps_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .reqWrite(reqWrite), .reqRow(reqRow),
    .reqCol(reqCol), .reqWdata(reqWdata), .strobe(strobe),
    .rowHit(rowHit), .pendWrite(pendWrite), .rspValid(rspValid),
    .rspRdata(rspRdata), .dramAddr(dramAddr), .dramRasN(dramRasN),
    .dramCasN(dramCasN), .dramWeN(dramWeN), .dramOeN(dramOeN),
    .dramDqOut(dramDqOut), .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

endmodule

// File: tb/tb_dram_page_seq.sv
`timescale 1ns/1ps
module tb_dram_page_seq;

  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_REF_ACT = 2, REF = 300;
  localparam int LAT_FULL = T_RCD + T_CAS + 2;
  localparam int LAT_HIT  = T_CAS + 2;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [8:0] reqRow = 0, reqCol = 0;
  logic [7:0] reqWdata = 0;
  logic reqReady, rspValid;
  logic [7:0] rspRdata;
  logic [8:0] addr;
  logic rasN, casN, weN, oeN, dqOe;
  logic [7:0] dqOut, dqIn;

  always #2 clk = ~clk;

  dram_page_seq #(.ADDR_W(9), .DATA_W(8), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RP(T_RP), .T_REF_ACT(T_REF_ACT), .REF_INTERVAL(REF), .LATE_OE(1'b0)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspRdata(rspRdata), .dramAddr(addr), .dramRasN(rasN),
    .dramCasN(casN), .dramWeN(weN), .dramOeN(oeN), .dramDqOut(dqOut),
    .dramDqOe(dqOe), .dramDqIn(dqIn));

  // behavioural device model and pin monitor
  logic [7:0] mem [256];
  logic [8:0] curRow = 0;
  int vR2 = 0, vR3 = 0, vR5 = 0, vR6 = 0, vR7 = 0, vR8 = 0;
  int hiRun = 100, casLo = 0, sinceRas = 0, casInPeriod = 0;
  int refs = 0, lastRef = -1, casFalls = 0;
  logic pRas = 1, pCas = 1, pWe = 1, pOe = 1;

  assign dqIn = (!casN && !oeN) ? mem[{curRow[3:0], addr[3:0]}] : 8'h00;

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 1);
    end else begin
      if (pRas && !rasN) begin
        if (hiRun < T_RP) vR5++;
        curRow = addr; sinceRas = 0; casInPeriod = 0;
      end
      if (!rasN) sinceRas++;
      if (!pRas && rasN && casInPeriod == 0) begin
        if (int'(curRow) != (lastRef + 1) % 512) vR8++;
        lastRef = int'(curRow); refs++;
      end
      hiRun = rasN ? hiRun + 1 : 0;
      if (pCas && !casN) begin
        casFalls++; casInPeriod++;
        if (rasN || sinceRas < T_RCD + 2) vR2++;
        if (!weN) begin
          if (pWe || !dqOe || !oeN) vR6++;
          mem[{curRow[3:0], addr[3:0]}] = dqOut;
        end else if (pOe) vR7++;
      end
      if (!casN && !pCas && weN != pWe) vR6++;
      if (!casN) casLo++;
      if (!pCas && casN) begin
        if (casLo != T_CAS) vR3++;
        casLo = 0;
      end
      pRas = rasN; pCas = casN; pWe = weN; pOe = oeN;
    end
  end

  int nChk = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input int act, input int exp_);
    nChk++;
    if (act != exp_) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  task automatic doReq(input logic wr, input int row, input int col, input logic [7:0] data,
                       output int waitN, output int lat, output logic [7:0] rd);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqRow = 9'(row); reqCol = 9'(col); reqWdata = data;
    #1;
    waitN = 0;
    while (!reqReady) begin @(negedge clk); #1; waitN++; end
    @(posedge clk); #1 reqValid = 0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rspValid);
    rd = rspRdata;
  endtask

  // kind: 0 = from idle, 1 = row hit, 2 = row miss
  typedef struct packed { logic wr; logic [8:0] row; logic [8:0] col; logic [7:0] data; logic [1:0] kind; } vec_t;
  localparam vec_t VEC [13] = '{
    {1'b1, 9'd3,  9'd5,  8'h3C, 2'd0},
    {1'b1, 9'd3,  9'd6,  8'hC3, 2'd1},
    {1'b0, 9'd3,  9'd5,  8'h00, 2'd1},
    {1'b0, 9'd3,  9'd6,  8'h00, 2'd1},
    {1'b1, 9'd7,  9'd5,  8'h5A, 2'd2},
    {1'b0, 9'd7,  9'd5,  8'h00, 2'd1},
    {1'b0, 9'd3,  9'd5,  8'h00, 2'd2},
    {1'b0, 9'd3,  9'd9,  8'h00, 2'd1},
    {1'b1, 9'd3,  9'd9,  8'h0F, 2'd1},
    {1'b0, 9'd3,  9'd9,  8'h00, 2'd1},
    {1'b0, 9'd0,  9'd0,  8'h00, 2'd2},
    {1'b1, 9'd15, 9'd15, 8'hFF, 2'd2},
    {1'b0, 9'd15, 9'd15, 8'h00, 2'd1}
  };

  logic [7:0] shadow [256];

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int w, l, refs0, waited, r0;
    logic [7:0] rd;
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 7 + 1);
    repeat (4) @(negedge clk);
    #1;
    // R1 during reset
    chk("R1", "rasN in reset", int'(rasN), 1);
    chk("R1", "casN in reset", int'(casN), 1);
    chk("R1", "weN in reset", int'(weN), 1);
    chk("R1", "oeN in reset", int'(oeN), 1);
    chk("R1", "dqOe in reset", int'(dqOe), 0);
    chk("R1", "rspValid in reset", int'(rspValid), 0);
    @(posedge clk); #1 rstN = 1;
    @(negedge clk); #1;
    chk("R1", "ready after reset", int'(reqReady), 1);
    chk("R1", "rasN after reset", int'(rasN), 1);

    for (int i = 0; i < 13; i++) begin
      vec_t v;
      int ew, el;
      v = VEC[i];
      doReq(v.wr, int'(v.row), int'(v.col), v.data, w, l, rd);
      ew = (v.kind == 2'd2) ? T_RP + 1 : 0;
      el = (v.kind == 2'd1) ? LAT_HIT : LAT_FULL;
      if (v.kind == 2'd0) chk("R2", "idle wait", w, ew);
      if (v.kind == 2'd0) chk("R2", "idle latency", l, el);
      if (v.kind == 2'd1) chk("R4", "hit wait", w, ew);
      if (v.kind == 2'd1) chk("R4", "hit latency", l, el);
      if (v.kind == 2'd2) chk("R5", "miss wait", w, ew);
      if (v.kind == 2'd2) chk("R5", "miss latency", l, el);
      if (v.wr) shadow[{v.row[3:0], v.col[3:0]}] = v.data;
      else chk("R7", "read data", int'(rd), int'(shadow[{v.row[3:0], v.col[3:0]}]));
    end
    chk("R2", "refresh-free table (no refresh yet)", refs, 0);

    // R8: idle refreshes, then the previously open row must be closed
    refs0 = refs;
    repeat (3 * REF) @(negedge clk);
    chk("R8", "refreshes in 3 intervals >= 2", (refs - refs0 >= 2) ? 1 : 0, 1);
    refs0 = refs;
    while (refs == refs0) @(negedge clk);
    repeat (10) @(negedge clk);
    doReq(1'b0, 15, 15, 8'h00, w, l, rd);
    chk("R8", "wait after refresh", w, 0);
    chk("R8", "row closed by refresh", l, LAT_FULL);
    chk("R8", "data kept", int'(rd), 8'hFF);

    // R9: back-to-back hits across a refresh
    waited = 0;
    for (int i = 0; i < 70; i++) begin
      r0 = refs;
      doReq(1'b0, 15, 15, 8'h00, w, l, rd);
      if (w > 0) begin
        waited++;
        chk("R9", "refresh ran during stall", (refs > r0) ? 1 : 0, 1);
        chk("R9", "latency after refresh stall", l, LAT_FULL);
      end
    end
    chk("R9", "stalls seen", (waited >= 1) ? 1 : 0, 1);

    // pin-level rules seen by the monitor
    chk("R2", "column strobe timing violations", vR2, 0);
    chk("R3", "column pulse width violations", vR3, 0);
    chk("R5", "precharge gap violations", vR5, 0);
    chk("R6", "write strobe violations", vR6, 0);
    chk("R7", "early read violations", vR7, 0);
    chk("R8", "refresh row order violations", vR8, 0);
    chk("R3", "column pulses observed", (casFalls > 20) ? 1 : 0, 1);
    finishRun();
  end

endmodule